// File: doc/BRIEF.md
# Cyclic Converter Phase Sequencer

This block is the digital timing controller for a converter that reuses one sampling capacitor array, one flash quantiser and one residue amplifier for several sub-conversions. A start request runs a conversion: the array takes the input, the flash quantiser resolves a code, the code goes to the array DAC, the feedback capacitors are cleared, the amplifier builds the residue, and the array takes the amplified residue in again. The convert, apply, clear, amplify and resample loop runs four times in total. The four quantiser codes are captured and presented together with a one-cycle valid strobe.

The length of every timed phase is set by input in clock cycles and latched when the conversion starts. A calibration mode keeps the held input. It skips input sampling and the first quantisation and drives a forced DAC code of plus or minus one in the first loop. The clear switch and the amplifier-connect switch never overlap, and a programmable dead time separates them.

Top module: `cyc_adc_seq`

## Requirements
- R1: After a start request in idle, the conversion runs, per loop k = 0..3, the phases sample (input sample switch when k=0, residue resample switch otherwise), hold-tail, flash, apply, dead, clear (phi2), dead, amplify (phi1). A dead phase separates loops. After loop 3 comes one done cycle, then idle.
- R2: flash_en is never high together with hold_en, and it rises only after hold_en has fallen.
- R3: At the end of every sampling phase the sample switch (samp_in_en or resamp_en) turns off one cycle before hold_en.
- R4: phi1 and phi2 are never high together. Every gap between the fall of one and the rise of the other is at least max(len_dead,1) cycles, and the gap from phi2 falling to phi1 rising is exactly max(len_dead,1).
- R5: phi1 is low during every sampling cycle and falls at least max(len_dead,1) cycles before a resample starts.
- R6: phi2 rises only after the flash phase has ended and dac_load has pulsed for the same loop.
- R7: The sample, flash, clear, amplify and dead phases last max(len,1) cycles each, with lengths taken at start. The hold-tail, apply and done phases last one cycle each.
- R8: When cal_mode is high at start, loop 0 has no sampling and no flash phase and begins at apply. Its DAC and captured code is 6'b000001 (+1) when cal_neg=0 and 6'b111111 (-1) when cal_neg=1. Loops 1..3 run as normal, with resampling.
- R9: The code captured on the last flash cycle of loop k is driven on dac_code from the apply cycle and stored in codes[6k+5:6k]. codes_valid is high for exactly one cycle, the done cycle.
- R10: busy is high from the cycle after an accepted start through the codes_valid cycle. A start while busy is ignored and changes neither timing nor the number of valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Conversion request, taken in idle only |
| cal_mode | input | 1 | Calibration conversion select |
| cal_neg | input | 1 | Forced code sign in calibration: 0 gives +1, 1 gives -1 |
| len_samp | input | 8 | Sampling phase length |
| len_flash | input | 8 | Flash phase length |
| len_reset | input | 8 | Feedback clear (phi2) length |
| len_amp | input | 8 | Amplify (phi1) length |
| len_dead | input | 8 | Dead time between switch phases |
| flash_code | input | 6 | Signed code from the flash quantiser |
| samp_in_en | output | 1 | Input sampling switch |
| resamp_en | output | 1 | Residue resampling switch |
| hold_en | output | 1 | Sample-and-hold enable |
| flash_en | output | 1 | Flash comparator enable |
| dac_load | output | 1 | Strobe to apply dac_code to the array |
| dac_code | output | 6 | Code applied to the array |
| phi1 | output | 1 | Amplifier-to-array connect switch |
| phi2 | output | 1 | Feedback capacitor clear switch |
| busy | output | 1 | Conversion in progress |
| codes_valid | output | 1 | One-cycle strobe: codes complete |
| codes | output | 24 | Four signed 6-bit codes, loop 0 in the low bits |

## Verification
The assertions assume that start and cal_mode are synchronous levels and that flash_code is stable by the last flash cycle. They place no condition on the phase lengths, because zero lengths are stretched to one cycle. The bench drives every input half a cycle away from the sampling edge. It changes flash_code only after each apply strobe, so each captured code is known in advance. It also covers zero lengths, both calibration signs and a start raised mid-conversion.

// File: rtl/cyc_seq_pkg.sv
// Shared phase encoding for the cyclic converter sequencer.
// Assumes: consumers decode outputs from the phase value only.
package cyc_seq_pkg;
    typedef enum logic [3:0] {
        PH_IDLE, PH_SAMP, PH_TAIL, PH_FLASH, PH_APPLY,
        PH_DEAD_A, PH_CLEAR, PH_DEAD_B, PH_AMP, PH_DEAD_C, PH_DONE
    } phase_t;
endpackage

// File: rtl/cyc_seq_timer.sv
// Down counter that times one phase.
// Assumes: load is pulsed on every phase change; expired is high when the count is zero.
module cyc_seq_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    output logic             expired
);
    logic [LEN_W-1:0] cnt;

    // count down from the loaded value and hold at zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/cyc_seq_codebank.sv
// Stores one signed code per loop and presents all of them packed.
// Assumes: wr_idx is below N_CYC whenever wr_en is high.
module cyc_seq_codebank #(
    parameter int N_CYC  = 4,
    parameter int CODE_W = 6,
    localparam int CYC_W = (N_CYC > 1) ? $clog2(N_CYC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CYC_W-1:0]        wr_idx,
    input  logic [CODE_W-1:0]       wr_data,
    output logic [N_CYC*CODE_W-1:0] codes
);
    for (genvar k = 0; k < N_CYC; k++) begin : g_slot
        logic [CODE_W-1:0] slot_q;
        // capture the code that belongs to loop k
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (wr_en && wr_idx == CYC_W'(k))
                slot_q <= wr_data;
        end
        assign codes[k*CODE_W +: CODE_W] = slot_q;
    end
endmodule

// File: rtl/cyc_seq_fsm.sv
// Phase state machine: steps through the sample, flash, apply, clear and amplify
// phases for N_CYC loops and decodes the switch enables from the phase.
// Assumes: start and cal_mode are synchronous; lengths are sampled only at start.
module cyc_seq_fsm
    import cyc_seq_pkg::*;
#(
    parameter int N_CYC  = 4,
    parameter int LEN_W  = 8,
    parameter int CODE_W = 6,
    localparam int CYC_W = (N_CYC > 1) ? $clog2(N_CYC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cal_mode,
    input  logic              cal_neg,
    input  logic [LEN_W-1:0]  len_samp,
    input  logic [LEN_W-1:0]  len_flash,
    input  logic [LEN_W-1:0]  len_reset,
    input  logic [LEN_W-1:0]  len_amp,
    input  logic [LEN_W-1:0]  len_dead,
    input  logic [CODE_W-1:0] flash_code,
    input  logic              expired,
    output logic              tmr_load,
    output logic [LEN_W-1:0]  tmr_val,
    output logic              wr_en,
    output logic [CYC_W-1:0]  wr_idx,
    output logic [CODE_W-1:0] wr_data,
    output logic              samp_in_en,
    output logic              resamp_en,
    output logic              hold_en,
    output logic              flash_en,
    output logic              dac_load,
    output logic [CODE_W-1:0] dac_code,
    output logic              phi1,
    output logic              phi2,
    output logic              busy,
    output logic              codes_valid
);
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(N_CYC - 1);
    localparam logic [CODE_W-1:0] CODE_POS = CODE_W'(1);
    localparam logic [CODE_W-1:0] CODE_NEG = '1;

    phase_t             ph, ph_nx;
    logic [CYC_W-1:0]   cyc;
    logic               cal_q, neg_q;
    logic [LEN_W-1:0]   c_samp, c_flash, c_reset, c_amp, c_dead;
    logic [CODE_W-1:0]  code_q;
    logic               accept;

    // length to count for a phase; zero behaves as one
    function automatic logic [LEN_W-1:0] cnt_of(input logic [LEN_W-1:0] len);
        return (len == '0) ? '0 : len - 1'b1;
    endfunction

    assign accept = (ph == PH_IDLE) && start;

    // next phase and timer reload value
    always_comb begin
        ph_nx   = ph;
        tmr_val = '0;
        unique case (ph)
            PH_IDLE:   if (start) begin
                           ph_nx   = cal_mode ? PH_APPLY : PH_SAMP;
                           tmr_val = cal_mode ? '0 : cnt_of(len_samp);
                       end
            PH_SAMP:   if (expired) ph_nx = PH_TAIL;
            PH_TAIL:   begin ph_nx = PH_FLASH; tmr_val = cnt_of(c_flash); end
            PH_FLASH:  if (expired) ph_nx = PH_APPLY;
            PH_APPLY:  begin ph_nx = PH_DEAD_A; tmr_val = cnt_of(c_dead); end
            PH_DEAD_A: if (expired) begin ph_nx = PH_CLEAR; tmr_val = cnt_of(c_reset); end
            PH_CLEAR:  if (expired) begin ph_nx = PH_DEAD_B; tmr_val = cnt_of(c_dead); end
            PH_DEAD_B: if (expired) begin ph_nx = PH_AMP; tmr_val = cnt_of(c_amp); end
            PH_AMP:    if (expired) begin
                           ph_nx   = (cyc == LAST_CYC) ? PH_DONE : PH_DEAD_C;
                           tmr_val = (cyc == LAST_CYC) ? '0 : cnt_of(c_dead);
                       end
            PH_DEAD_C: if (expired) begin ph_nx = PH_SAMP; tmr_val = cnt_of(c_samp); end
            PH_DONE:   ph_nx = PH_IDLE;
            default:   ph_nx = PH_IDLE;
        endcase
    end

    assign tmr_load = (ph_nx != ph);

    // code selection: forced in calibration loop 0, otherwise the flash result
    assign wr_en   = (accept && cal_mode) || (ph == PH_FLASH && expired);
    assign wr_idx  = cyc;
    assign wr_data = (ph == PH_IDLE) ? (cal_neg ? CODE_NEG : CODE_POS) : flash_code;

    // phase register, loop index, configuration latch and applied code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            cyc     <= '0;
            cal_q   <= 1'b0;
            neg_q   <= 1'b0;
            c_samp  <= '0;
            c_flash <= '0;
            c_reset <= '0;
            c_amp   <= '0;
            c_dead  <= '0;
            code_q  <= '0;
        end else begin
            ph <= ph_nx;
            if (accept) begin
                cyc     <= '0;
                cal_q   <= cal_mode;
                neg_q   <= cal_neg;
                c_samp  <= len_samp;
                c_flash <= len_flash;
                c_reset <= len_reset;
                c_amp   <= len_amp;
                c_dead  <= len_dead;
            end else if (ph == PH_AMP && expired && cyc != LAST_CYC) begin
                cyc <= cyc + 1'b1;
            end else if (ph == PH_DONE) begin
                cyc <= '0;
            end
            if (wr_en)
                code_q <= wr_data;
        end
    end

    // switch enables decoded from the phase
    assign samp_in_en  = (ph == PH_SAMP) && (cyc == '0);
    assign resamp_en   = (ph == PH_SAMP) && (cyc != '0);
    assign hold_en     = (ph == PH_SAMP) || (ph == PH_TAIL);
    assign flash_en    = (ph == PH_FLASH);
    assign dac_load    = (ph == PH_APPLY);
    assign dac_code    = code_q;
    assign phi1        = (ph == PH_AMP);
    assign phi2        = (ph == PH_CLEAR);
    assign busy        = (ph != PH_IDLE);
    assign codes_valid = (ph == PH_DONE);

    // ---------------- assertions ----------------
    assert_flash_after_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_en) |-> !hold_en && $past(!flash_en));
    assert_no_flash_in_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_en && hold_en));
    assert_switch_opens_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_en) |-> $past(!samp_in_en && !resamp_en));
    assert_phi_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(phi1 && phi2));
    assert_dead_rise_phi2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi2) |-> $past(!phi1));
    assert_dead_rise_phi1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi1) |-> $past(!phi2));
    assert_phi1_open_sampling_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_in_en || resamp_en) |-> !phi1 && $past(!phi1));
    assert_clear_after_flash_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi2) |-> !flash_en && $past(!flash_en));
    assert_cal_no_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_q && busy |-> !samp_in_en);
    assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        codes_valid |=> !codes_valid && !busy);
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !codes_valid) |=> busy);
    assert_neg_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(neg_q));
endmodule

// File: rtl/cyc_adc_seq.sv
// Top of the cyclic converter phase sequencer: phase machine, phase timer and
// code store. Assumes one clock domain and synchronous control inputs.
module cyc_adc_seq #(
    parameter int N_CYC  = 4,
    parameter int LEN_W  = 8,
    parameter int CODE_W = 6,
    localparam int CYC_W = (N_CYC > 1) ? $clog2(N_CYC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    cal_mode,
    input  logic                    cal_neg,
    input  logic [LEN_W-1:0]        len_samp,
    input  logic [LEN_W-1:0]        len_flash,
    input  logic [LEN_W-1:0]        len_reset,
    input  logic [LEN_W-1:0]        len_amp,
    input  logic [LEN_W-1:0]        len_dead,
    input  logic [CODE_W-1:0]       flash_code,
    output logic                    samp_in_en,
    output logic                    resamp_en,
    output logic                    hold_en,
    output logic                    flash_en,
    output logic                    dac_load,
    output logic [CODE_W-1:0]       dac_code,
    output logic                    phi1,
    output logic                    phi2,
    output logic                    busy,
    output logic                    codes_valid,
    output logic [N_CYC*CODE_W-1:0] codes
);
    logic              tmr_load, expired, wr_en;
    logic [LEN_W-1:0]  tmr_val;
    logic [CYC_W-1:0]  wr_idx;
    logic [CODE_W-1:0] wr_data;

    cyc_seq_timer #(.LEN_W(LEN_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(expired)
    );

    cyc_seq_fsm #(.N_CYC(N_CYC), .LEN_W(LEN_W), .CODE_W(CODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cal_mode(cal_mode), .cal_neg(cal_neg),
        .len_samp(len_samp), .len_flash(len_flash), .len_reset(len_reset),
        .len_amp(len_amp), .len_dead(len_dead), .flash_code(flash_code),
        .expired(expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .samp_in_en(samp_in_en), .resamp_en(resamp_en), .hold_en(hold_en),
        .flash_en(flash_en), .dac_load(dac_load), .dac_code(dac_code),
        .phi1(phi1), .phi2(phi2), .busy(busy), .codes_valid(codes_valid)
    );

    cyc_seq_codebank #(.N_CYC(N_CYC), .CODE_W(CODE_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .codes(codes)
    );
endmodule

// File: tb/cyc_adc_seq_bench.sv
module cyc_adc_seq_bench;
    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cal_mode = 1'b0, cal_neg = 1'b0;
    logic [7:0] len_samp = 8'd1, len_flash = 8'd1, len_reset = 8'd1, len_amp = 8'd1, len_dead = 8'd1;
    logic [5:0] flash_code = '0;
    logic samp_in_en, resamp_en, hold_en, flash_en, dac_load, phi1, phi2, busy, codes_valid;
    logic [5:0] dac_code;
    logic [23:0] codes;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    cyc_adc_seq u_cyc_adc_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cal_mode(cal_mode), .cal_neg(cal_neg),
        .len_samp(len_samp), .len_flash(len_flash), .len_reset(len_reset),
        .len_amp(len_amp), .len_dead(len_dead), .flash_code(flash_code),
        .samp_in_en(samp_in_en), .resamp_en(resamp_en), .hold_en(hold_en),
        .flash_en(flash_en), .dac_load(dac_load), .dac_code(dac_code),
        .phi1(phi1), .phi2(phi2), .busy(busy), .codes_valid(codes_valid), .codes(codes)
    );

    // monitor state, reset by each scenario
    logic [5:0] tbl [4];
    logic [5:0] seen_dac [4];
    int e_s, e_f, e_r, e_a, e_d;
    int n_load, n_valid, n_busy, n_insamp, n_resamp, n_flash, mon_err, ord_err;
    int run_smp, run_fl, run_p1, run_p2, gap_p1, gap_p2;
    logic p_smp, p_fl, p_p1, p_p2;
    logic dac_fresh;

    function automatic int ef(input logic [7:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic mon_clear();
        n_load = 0; n_valid = 0; n_busy = 0; n_insamp = 0; n_resamp = 0; n_flash = 0;
        mon_err = 0; ord_err = 0;
        run_smp = 0; run_fl = 0; run_p1 = 0; run_p2 = 0; gap_p1 = 100; gap_p2 = 100;
        p_smp = 0; p_fl = 0; p_p1 = 0; p_p2 = 0;
        dac_fresh = 0;
        flash_code = tbl[0];
    endtask

    // observe outputs at the falling edge
    always @(negedge clk) if (rst_n) begin
        logic smp;
        smp = samp_in_en | resamp_en;
        if (busy) n_busy++;
        if (codes_valid) n_valid++;
        if (samp_in_en && !p_smp) n_insamp++;
        if (resamp_en && !p_smp) n_resamp++;
        if (flash_en && !p_fl) n_flash++;
        if (flash_en && hold_en) ord_err++;                 // R2
        if (phi1 && phi2) ord_err++;                        // R4
        if (smp && phi1) ord_err++;                         // R5
        if (phi2 && dac_fresh == 0) ord_err++;              // R6
        if (p_smp && !smp && !hold_en) ord_err++;           // R3: tail cycle
        if (p_smp && !smp && hold_en) run_smp = run_smp;    // tail observed
        if (p_fl && !flash_en) dac_fresh = 0;
        if (dac_load) begin
            if (n_load < 4) seen_dac[n_load] = dac_code;
            n_load++;
            dac_fresh = 1;
            flash_code = tbl[n_load % 4];
        end
        // run lengths (R7)
        if (smp) run_smp++; else if (p_smp) begin if (run_smp != e_s) mon_err++; run_smp = 0; end
        if (flash_en) run_fl++; else if (p_fl) begin if (run_fl != e_f) mon_err++; run_fl = 0; end
        if (phi2) run_p2++; else if (p_p2) begin if (run_p2 != e_r) mon_err++; run_p2 = 0; end
        if (phi1) run_p1++; else if (p_p1) begin if (run_p1 != e_a) mon_err++; run_p1 = 0; end
        // dead gaps (R4, R5)
        if (phi2 && !p_p2 && gap_p1 < e_d) mon_err++;
        if (phi1 && !p_p1 && gap_p2 != e_d && gap_p2 != 100) mon_err++;
        if (smp && !p_smp && gap_p1 < e_d && gap_p1 != 100) mon_err++;
        if (phi1) gap_p1 = 0; else if (gap_p1 < 100) gap_p1++;
        if (phi2) gap_p2 = 0; else if (gap_p2 < 100) gap_p2++;
        if (phi2 && gap_p1 == 100) gap_p1 = 100;
        p_smp = smp; p_fl = flash_en; p_p1 = phi1; p_p2 = phi2;
    end

    task automatic launch(input bit cal, input bit neg, input logic [7:0] s, f, r, a, d);
        @(posedge clk); #1;
        cal_mode = cal; cal_neg = neg;
        len_samp = s; len_flash = f; len_reset = r; len_amp = a; len_dead = d;
        e_s = ef(s); e_f = ef(f); e_r = ef(r); e_a = ef(a); e_d = ef(d);
        mon_clear();
        start = 1;
        @(posedge clk); #1;
        start = 0;
        // change the lengths after start to prove they were latched (R7)
        len_samp = 8'd9; len_flash = 8'd9; len_reset = 8'd9; len_amp = 8'd9; len_dead = 8'd9;
        cal_mode = ~cal; cal_neg = ~neg;
    endtask

    task automatic wait_done(input int extra_start_at);
        int t;
        t = 0;
        while (n_valid == 0 && t < 2000) begin
            @(posedge clk); #1;
            t++;
            if (t == extra_start_at) start = 1;
            else start = 0;
        end
        start = 0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic verify(input string nm, input bit cal, input bit neg);
        int exp_busy;
        logic [5:0] forced;
        exp_busy = 4 * (e_s + 1 + e_f + 1 + 2*e_d + e_r + e_a) + 3*e_d + 1;
        if (cal) exp_busy -= (e_s + 1 + e_f);
        forced = neg ? 6'b111111 : 6'b000001;
        chk(n_busy == exp_busy, {nm, " R1/R10 busy length"}, n_busy, exp_busy);
        chk(n_valid == 1, {nm, " R9 single valid"}, n_valid, 1);
        chk(n_load == 4, {nm, " R1 apply count"}, n_load, 4);
        chk(n_flash == (cal ? 3 : 4), {nm, " R8 flash phases"}, n_flash, cal ? 3 : 4);
        chk(n_insamp == (cal ? 0 : 1), {nm, " R8 input samples"}, n_insamp, cal ? 0 : 1);
        chk(n_resamp == 3, {nm, " R5 resamples"}, n_resamp, 3);
        chk(mon_err == 0, {nm, " R7 phase lengths and R4 dead time"}, mon_err, 0);
        chk(ord_err == 0, {nm, " R2 R3 R6 ordering"}, ord_err, 0);
        chk(!busy, {nm, " R10 idle after"}, busy, 0);
        for (int k = 0; k < 4; k++) begin
            logic [5:0] ex;
            ex = (cal && k == 0) ? forced : tbl[k];
            chk(codes[6*k +: 6] == ex, {nm, " R9 stored code"}, codes[6*k +: 6], ex);
            chk(seen_dac[k] == ex, {nm, " R9 dac_code"}, seen_dac[k], ex);
        end
    endtask

    task automatic t_reset();
        chk({samp_in_en, resamp_en, hold_en, flash_en, dac_load, phi1, phi2, busy, codes_valid} == 0,
            "R1 reset outputs", busy, 0);
        chk(codes == 0, "R9 reset codes", int'(codes), 0);
    endtask

    task automatic t_normal();
        tbl[0] = 6'd5; tbl[1] = 6'b111101; tbl[2] = 6'd31; tbl[3] = 6'b100000;
        launch(0, 0, 8'd3, 8'd2, 8'd2, 8'd4, 8'd1);
        wait_done(0);
        verify("normal", 0, 0);
    endtask

    task automatic t_zero_len();
        tbl[0] = 6'd1; tbl[1] = 6'd2; tbl[2] = 6'd3; tbl[3] = 6'd4;
        launch(0, 0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0);
        wait_done(0);
        verify("zero_len R7", 0, 0);
    endtask

    task automatic t_cal_pos();
        tbl[0] = 6'd17; tbl[1] = 6'd9; tbl[2] = 6'b110000; tbl[3] = 6'd12;
        launch(1, 0, 8'd2, 8'd3, 8'd1, 8'd5, 8'd2);
        wait_done(0);
        verify("cal_pos R8", 1, 0);
    endtask

    task automatic t_cal_neg();
        tbl[0] = 6'd0; tbl[1] = 6'd7; tbl[2] = 6'd8; tbl[3] = 6'b111000;
        launch(1, 1, 8'd4, 8'd1, 8'd3, 8'd2, 8'd3);
        wait_done(0);
        verify("cal_neg R8", 1, 1);
    endtask

    task automatic t_busy_start();
        tbl[0] = 6'd21; tbl[1] = 6'd22; tbl[2] = 6'd23; tbl[3] = 6'd24;
        launch(0, 0, 8'd2, 8'd2, 8'd2, 8'd2, 8'd2);
        wait_done(10);
        verify("start_while_busy R10", 0, 0);
        repeat (5) @(posedge clk);
        #1;
        chk(!busy, "R10 no restart", busy, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin tbl[k] = '0; seen_dac[k] = '0; end
        e_s = 1; e_f = 1; e_r = 1; e_a = 1; e_d = 1;
        mon_clear();
        repeat (4) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1;
        t_normal();
        t_zero_len();
        t_cal_pos();
        t_cal_neg();
        t_busy_start();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule